// File: doc/BRIEF.md
# Frame Ones-Accumulation Checker

This block computes a per-frame checksum of the video stream by counting set bits. On each pixel clock where the pixel-valid input is high, it takes one colour byte from the palette output (red, green or blue). It counts the 1 bits in that byte and adds the count to an 8-bit running sum. Carries out of bit 7 are dropped, so the sum wraps modulo 256. All eight bits of the byte are counted, even when the analog outputs use only six of them.

A frame-start pulse ends a frame. On that pulse the running sum is copied into a result register and the running sum restarts. The colour select is also captured on that pulse, so one frame always measures a single colour. A processor reads the result at any point during the next frame and compares it with the value expected for a still image. A mismatch points to a fault in the frame buffer, the pixel bus or the palette.

Top module: `ones_accum_top`

## Requirements
- R1: After reset the result output `frameSum` is 0, and the running sum is 0. With no valid pixels before the first frame start, that frame start also presents 0.
- R2: For each cycle with `pixValid` high, the number of 1 bits in the selected colour byte is added to the running sum. For example, 8'h41 adds 2.
- R3: All 8 bits of the colour byte are counted, including bits 7 and 6. 8'hC0 adds 2 and 8'hFF adds 8, so no single pixel adds more than 8.
- R4: The running sum is 8 bits wide and wraps modulo 256. For example, 40 pixels of 8'hFF in one frame give 64.
- R5: A cycle with `pixValid` low adds nothing, whatever the colour bytes are.
- R6: `chanSel` encoding: 2'b00 selects red, 2'b01 green, 2'b10 blue. 2'b11 selects no colour, so the frame's sum stays 0.
- R7: `chanSel` is sampled only in a cycle with `frameStart` high. A change at any other time has no effect on the frame in progress.
- R8: In a cycle with `frameStart` high, the running sum is copied to `frameSum`, which is visible after that clock edge. The running sum then restarts. A valid pixel in that same cycle is the first pixel of the new frame and uses the newly sampled select.
- R9: `frameSum` changes only at a clock edge where `frameStart` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | High for active video pixels |
| frameStart | input | 1 | One-cycle pulse marking the start of a frame |
| redByte | input | 8 | Red byte from the palette |
| grnByte | input | 8 | Green byte from the palette |
| bluByte | input | 8 | Blue byte from the palette |
| chanSel | input | 2 | Colour select (00 red, 01 green, 10 blue, 11 none) |
| frameSum | output | 8 | Ones-count total of the last complete frame |

## Verification
The hardest cases to reach are the ones where two events fall in the same edge. One is a select change and a valid pixel arriving on the frame-start cycle itself. The other is the running sum crossing 255 inside one frame. Directed sequences place a valid pixel with a new select exactly on the frame-start cycle. They also fill a frame with all-ones bytes until the sum wraps. Random stimulus then toggles the select mid-frame and mixes in blanking cycles and short frames, and a bench model predicts every frame result.

// File: rtl/ones_accum_pkg.sv
package ones_accum_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 3;
  localparam int SEL_W  = 2;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SEL_RED  = 2'd0;
  localparam sel_t SEL_GRN  = 2'd1;
  localparam sel_t SEL_BLU  = 2'd2;
  localparam sel_t SEL_NONE = 2'd3;

  typedef struct packed {
    logic capture;
    logic accEn;
  } accStrobe_t;
endpackage

// File: rtl/ones_accum_ctrl.sv
module ones_accum_ctrl
  import ones_accum_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixValid,
  input  logic       frameStart,
  input  sel_t       chanSel,
  output sel_t       heldSel,
  output sel_t       effSel,
  output accStrobe_t strobes
);
  sel_t selQ;

  // select is taken only on frame start; the start pixel already uses it
  always_ff @(posedge clk) begin
    if (!rstN) selQ <= SEL_RED;
    else if (frameStart) selQ <= chanSel;
  end

  always_comb begin
    effSel          = frameStart ? chanSel : selQ;
    strobes.capture = frameStart;
    strobes.accEn   = pixValid && (effSel != SEL_NONE);
  end

  assign heldSel = selQ;
endmodule

// File: rtl/ones_accum_dp.sv
module ones_accum_dp
  import ones_accum_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int SUM_W = 8,
  parameter int CH    = NUM_CH
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  accStrobe_t           strobes,
  input  sel_t                 effSel,
  input  logic [CH-1:0][DW-1:0] chBytes,
  output logic [SUM_W-1:0]     accQ,
  output logic [SUM_W-1:0]     resultQ
);
  localparam int CNT_W = $clog2(DW + 1);

  logic [DW-1:0]    pickByte;
  logic [CNT_W-1:0] onesCnt;
  logic [SUM_W-1:0] base;
  logic [SUM_W-1:0] accNext;

  // colour mux: one candidate per channel
  logic [CH-1:0][DW-1:0] masked;
  genvar gi;
  generate
    for (gi = 0; gi < CH; gi++) begin : g_mux
      assign masked[gi] = (effSel == sel_t'(gi)) ? chBytes[gi] : '0;
    end
  endgenerate

  always_comb begin
    pickByte = '0;
    for (int i = 0; i < CH; i++) pickByte |= masked[i];
  end

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < DW; i++) onesCnt += CNT_W'(pickByte[i]);
  end

  always_comb begin
    base    = strobes.capture ? '0 : accQ;
    accNext = base + (strobes.accEn ? SUM_W'(onesCnt) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      resultQ <= '0;
    end else begin
      accQ <= accNext;
      if (strobes.capture) resultQ <= accQ;
    end
  end
endmodule

// File: rtl/ones_accum_top.sv
module ones_accum_top
  import ones_accum_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixValid,
  input  logic       frameStart,
  input  logic [7:0] redByte,
  input  logic [7:0] grnByte,
  input  logic [7:0] bluByte,
  input  logic [1:0] chanSel,
  output logic [7:0] frameSum
);
  accStrobe_t             strobes;
  sel_t                   heldSel;
  sel_t                   effSel;
  logic [7:0]             accQ;
  logic [NUM_CH-1:0][7:0] chBytes;

  assign chBytes = {bluByte, grnByte, redByte};

  ones_accum_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
    .chanSel(chanSel), .heldSel(heldSel), .effSel(effSel), .strobes(strobes)
  );

  ones_accum_dp #(.DW(8), .SUM_W(8), .CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .effSel(effSel),
    .chBytes(chBytes), .accQ(accQ), .resultQ(frameSum)
  );
endmodule

// File: rtl/ones_accum_chk.sv
module ones_accum_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pixValid,
  input logic       frameStart,
  input logic [1:0] heldSel,
  input logic [7:0] accQ,
  input logic [7:0] frameSum
);
  p_result_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(frameSum));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> frameSum == $past(accQ));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !pixValid) |=> accQ == 8'd0);

  p_blank_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!pixValid && !frameStart) |=> $stable(accQ));

  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(heldSel));

  p_step_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> 8'(accQ - $past(accQ)) <= 8'd8);

  p_none_adds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && heldSel == 2'd3) |=> $stable(accQ));

  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> (frameSum == 8'd0 && accQ == 8'd0));
endmodule

bind ones_accum_top ones_accum_chk u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
  .heldSel(heldSel), .accQ(accQ), .frameSum(frameSum)
);

// File: tb/tb_ones_accum_top.sv
module tb_ones_accum_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixValid = 1'b0;
  logic       frameStart = 1'b0;
  logic [7:0] redByte = '0, grnByte = '0, bluByte = '0;
  logic [1:0] chanSel = '0;
  logic [7:0] frameSum;

  int checks = 0;
  int errors = 0;
  int unsigned mAcc = 0, mRes = 0;
  logic [1:0] mSel = 2'd0;

  always #2.5 clk = ~clk;

  ones_accum_top dut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
    .redByte(redByte), .grnByte(grnByte), .bluByte(bluByte),
    .chanSel(chanSel), .frameSum(frameSum)
  );

  function automatic int unsigned ones(input logic [7:0] b);
    int unsigned n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return n;
  endfunction

  function automatic int unsigned pick(input logic [1:0] s, input logic [7:0] r,
                                       input logic [7:0] g, input logic [7:0] b);
    case (s)
      2'd0: return ones(r);
      2'd1: return ones(g);
      2'd2: return ones(b);
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int unsigned exp);
    checks++;
    if (frameSum !== 8'(exp)) begin
      errors++;
      $display("FAIL %s frameSum=%0d expected=%0d", req, frameSum, exp);
    end
  endtask

  // drive one cycle, advance the model at the edge, compare after it
  task automatic cyc(input logic fs, input logic pv, input logic [7:0] r,
                     input logic [7:0] g, input logic [7:0] b,
                     input logic [1:0] s, input string req);
    frameStart = fs; pixValid = pv; redByte = r; grnByte = g; bluByte = b;
    chanSel = s;
    @(posedge clk);
    if (fs) begin
      mRes = mAcc; mSel = s; mAcc = 0;
    end
    if (pv) mAcc = (mAcc + pick(mSel, r, g, b)) % 256;
    @(negedge clk);
    check(req, mRes);
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 2'd0, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset", 0);
    // R1: empty first frame presents 0
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd0, "R1");
    idle("R1");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd0, "R1");
    check("R1 empty frame", 0);

    // R2: 8'h41 adds 2
    cyc(1'b0, 1'b1, 8'h41, 8'h00, 8'h00, 2'd1, "R2");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd0, "R2");
    check("R2 h41", 2);

    // R3: high bits counted
    cyc(1'b0, 1'b1, 8'hC0, 8'h00, 8'h00, 2'd0, "R3");
    cyc(1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 2'd0, "R3");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd0, "R3");
    check("R3 hC0+hFF", 10);

    // R4: 40 x hFF wraps to 64
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 2'd0, "R4");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd1, "R4");
    check("R4 wrap", 64);

    // R5: blanking ignored (green selected)
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 2'd1, "R5");
    cyc(1'b0, 1'b1, 8'hFF, 8'h03, 8'hFF, 2'd1, "R5");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd2, "R5");
    check("R5 blank", 2);

    // R6: blue select then none select
    cyc(1'b0, 1'b1, 8'hFF, 8'hFF, 8'h07, 2'd2, "R6");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd3, "R6");
    check("R6 blue", 3);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 8'hFF, 8'hFF, 8'hFF, 2'd3, "R6");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd0, "R6");
    check("R6 none", 0);

    // R7: mid-frame select change ignored (red held)
    cyc(1'b0, 1'b1, 8'h01, 8'hFF, 8'hFF, 2'd1, "R7");
    cyc(1'b0, 1'b1, 8'h01, 8'hFF, 8'hFF, 2'd2, "R7");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd1, "R7");
    check("R7 held red", 2);

    // R8: pixel on frame-start cycle counts into new frame with new select
    cyc(1'b0, 1'b1, 8'h00, 8'h0F, 8'h00, 2'd0, "R8");
    cyc(1'b1, 1'b1, 8'hFF, 8'h00, 8'h3F, 2'd2, "R8");
    check("R8 capture", 4);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd0, "R8");
    check("R8 start pixel", 6);

    // R9 plus all: random frames, checked every cycle
    for (int f = 0; f < 60; f++) begin
      int len = 1 + ($urandom % 60);
      cyc(1'b1, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
          2'($urandom), "R9 R8");
      for (int i = 0; i < len; i++)
        cyc(1'b0, ($urandom % 4) != 0, 8'($urandom), 8'($urandom), 8'($urandom),
            2'($urandom), "R9 R2 R7");
    end
    // reset mid-run returns to zero
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mAcc = 0; mRes = 0; mSel = 2'd0;
    check("R1 re-reset", 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule